// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block turns a single host request into the series of write cycles that an 8-bit parallel NOR flash needs before it will program a byte or erase a region. The host presents an opcode, a target address and a data byte with a one-cycle valid strobe. The sequencer then drives the flash address, data, active-low chip-enable and active-low write-enable lines through every write of the command, in order. It pulses `done` once the final write and its trailing gap are over. Polling the flash for completion of the internal program or erase is left to the host.

Two configuration inputs adapt the unlock writes to the attached chip. `cfg_shift` exchanges the two unlock addresses, for devices wired in byte mode. `cfg_addr_mask` is ANDed onto every unlock address so that it fits the chip's address width. `cfg_slow` adds a fixed idle gap, measured in clocks, after every write. All three are captured when a request is accepted. Requests are taken only while the block is idle. An opcode outside the supported set completes at once with an error flag and causes no bus traffic.

Top module: `pflash_cmd_seq`

## Requirements
- R1: After reset `flash_we_n` and `flash_ce_n` are 1, `flash_addr` is 0, and `busy`, `done` and `err` are 0.
- R2: Every supported command opens with 0xAA written to unlock address A, then 0x55 written to unlock address B. With `cfg_shift` = 0, A is 0x5555 and B is 0x2AAA.
- R3: With `cfg_shift` = 1 the two unlock addresses are exchanged, so A is 0x2AAA and B is 0x5555.
- R4: Each unlock address is ANDed with `cfg_addr_mask` before it is driven. The host target address is driven unmasked.
- R5: Opcode 0 (byte program) issues four writes: the opening pair, then 0xA0 to A, then `req_data` to the target address.
- R6: Opcodes 1, 2 and 3 (sector, block and chip erase) issue six writes: the opening pair, 0x80 to A, 0xAA to A, 0x55 to B, and a final write. That final write is 0x30 to the target for opcode 1, 0x50 to the target for opcode 2, and 0x10 to A for opcode 3.
- R7: Each write has one setup cycle with chip-enable low and write-enable high. It then has WE_CYCLES cycles with write-enable low and one hold cycle with write-enable high and chip-enable low. The address does not change while write-enable is low or during the hold cycle. Write-enable is never low while chip-enable is high.
- R8: When `cfg_slow` = 1, every write is followed by GAP_CYCLES cycles with chip-enable high; when 0, no gap is inserted. `done` is a one-cycle pulse. It is visible N*(2+WE_CYCLES+gap) cycles after the accepting edge, where N is 4 for a program and 6 for an erase.
- R9: Opcodes 4 to 7 are unsupported. For these, `done` and `err` are high in the cycle after acceptance, and no chip-enable or write-enable activity occurs.
- R10: A request presented while `busy` is high is ignored. It adds no writes and no extra `done` pulse.
- R11: A request may be presented in the same cycle that `done` is high. It is accepted and `busy` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_op | input | 3 | Opcode: 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | ADDR_W | Target address for program, sector or block erase |
| req_data | input | 8 | Byte to program |
| cfg_shift | input | 1 | Exchange the two unlock addresses |
| cfg_addr_mask | input | ADDR_W | Mask ANDed onto unlock addresses |
| cfg_slow | input | 1 | Insert the idle gap after each write |
| busy | output | 1 | A command sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Set together with done for an unsupported opcode |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_dq | output | 8 | Flash data bus (write direction) |
| flash_we_n | output | 1 | Flash write-enable, active low |
| flash_ce_n | output | 1 | Flash chip-enable, active low |

## Verification
The completion pulse of one command and the acceptance of the next can fall in the same cycle. This is the case because the sequencer returns to idle in the same edge that raises `done`. The bench provokes this by issuing every new request at the very negedge where it first sees `done`. It judges the result in two ways. `busy` must read high one cycle later, and the scoreboard must receive the second command's writes with the exact cycle count that R8 predicts. A request that arrives mid-sequence is also raised deliberately. The scoreboard must then show neither an extra write nor an extra `done`.

// File: rtl/pflash_seq_pkg.sv
package pflash_seq_pkg;

  localparam int BYTE_W = 8;

  localparam logic [2:0] OP_PROG  = 3'd0;
  localparam logic [2:0] OP_SECT  = 3'd1;
  localparam logic [2:0] OP_BLK   = 3'd2;
  localparam logic [2:0] OP_CHIP  = 3'd3;

  localparam logic [15:0] UNLOCK_HI = 16'h5555;
  localparam logic [15:0] UNLOCK_LO = 16'h2AAA;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_GAP
  } bus_phase_t;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

  function automatic logic op_known(input logic [2:0] op);
    return op <= OP_CHIP;
  endfunction

  // index of the final write of a supported command
  function automatic logic [2:0] op_last_step(input logic [2:0] op);
    return (op == OP_PROG) ? 3'd3 : 3'd5;
  endfunction

  function automatic logic [7:0] erase_final_byte(input logic [2:0] op);
    case (op)
      OP_SECT: return 8'h30;
      OP_BLK:  return 8'h50;
      default: return 8'h10;
    endcase
  endfunction

endpackage

// File: rtl/pflash_step_rom.sv
module pflash_step_rom
  import pflash_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [2:0]        op,
  input  logic [2:0]        step,
  input  logic              shift,
  input  logic [ADDR_W-1:0] mask,
  input  logic [ADDR_W-1:0] target,
  input  logic [7:0]        data,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        dq
);

  logic [ADDR_W-1:0] ua, ub;

  always_comb begin
    ua = (shift ? ADDR_W'(UNLOCK_LO) : ADDR_W'(UNLOCK_HI)) & mask;
    ub = (shift ? ADDR_W'(UNLOCK_HI) : ADDR_W'(UNLOCK_LO)) & mask;
  end

  always_comb begin
    addr = '0;
    dq   = '0;
    case (step)
      3'd0: begin addr = ua; dq = 8'hAA; end
      3'd1: begin addr = ub; dq = 8'h55; end
      3'd2: begin addr = ua; dq = (op == OP_PROG) ? 8'hA0 : 8'h80; end
      3'd3: begin
        if (op == OP_PROG) begin addr = target; dq = data; end
        else begin addr = ua; dq = 8'hAA; end
      end
      3'd4: begin addr = ub; dq = 8'h55; end
      3'd5: begin
        addr = (op == OP_CHIP) ? ua : target;
        dq   = erase_final_byte(op);
      end
      default: begin addr = '0; dq = '0; end
    endcase
  end

endmodule

// File: rtl/pflash_bus_cycle.sv
module pflash_bus_cycle
  import pflash_seq_pkg::*;
#(
  parameter int WE_CYCLES  = 3,
  parameter int GAP_CYCLES = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       slow,
  output bus_phase_t phase,
  output logic       wr_last
);

  localparam int MAXC     = (WE_CYCLES > GAP_CYCLES) ? WE_CYCLES : GAP_CYCLES;
  localparam int CW       = $clog2(MAXC + 1);
  localparam int WE_LOAD  = (WE_CYCLES  > 0) ? WE_CYCLES - 1  : 0;
  localparam int GAP_LOAD = (GAP_CYCLES > 0) ? GAP_CYCLES - 1 : 0;

  logic [CW-1:0] cnt;
  logic          gap_on;

  assign gap_on  = slow && (GAP_CYCLES != 0);
  assign wr_last = ((phase == PH_HOLD) && !gap_on) ||
                   ((phase == PH_GAP) && (cnt == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE:   if (go) phase <= PH_SETUP;
        PH_SETUP: begin
          phase <= PH_STROBE;
          cnt   <= CW'(WE_LOAD);
        end
        PH_STROBE: begin
          if (cnt == '0) phase <= PH_HOLD;
          else           cnt   <= cnt - 1'b1;
        end
        PH_HOLD: begin
          if (gap_on) begin
            phase <= PH_GAP;
            cnt   <= CW'(GAP_LOAD);
          end else begin
            phase <= go ? PH_SETUP : PH_IDLE;
          end
        end
        PH_GAP: begin
          if (cnt == '0) phase <= go ? PH_SETUP : PH_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pflash_cmd_seq.sv
module pflash_cmd_seq
  import pflash_seq_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int WE_CYCLES  = 3,
  parameter int GAP_CYCLES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              cfg_shift,
  input  logic [ADDR_W-1:0] cfg_addr_mask,
  input  logic              cfg_slow,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [7:0]        flash_dq,
  output logic              flash_we_n,
  output logic              flash_ce_n
);

  seq_state_t        state;
  logic [2:0]        op_q, step_q;
  logic [ADDR_W-1:0] addr_q, mask_q;
  logic [7:0]        data_q;
  logic              shift_q, slow_q, done_q, err_q;

  // named events for the checker
  logic       accept_ok, accept_bad, last_step, go, wr_last, ce_active;
  bus_phase_t phase;
  logic [ADDR_W-1:0] rom_addr;
  logic [7:0]        rom_dq;

  assign accept_ok  = (state == ST_IDLE) && req_valid && op_known(req_op);
  assign accept_bad = (state == ST_IDLE) && req_valid && !op_known(req_op);
  assign last_step  = (step_q == op_last_step(op_q));
  assign go         = accept_ok || ((state == ST_RUN) && wr_last && !last_step);

  pflash_bus_cycle #(.WE_CYCLES(WE_CYCLES), .GAP_CYCLES(GAP_CYCLES)) u_bus (
    .clk(clk), .rst_n(rst_n), .go(go), .slow(slow_q),
    .phase(phase), .wr_last(wr_last)
  );

  pflash_step_rom #(.ADDR_W(ADDR_W)) u_rom (
    .op(op_q), .step(step_q), .shift(shift_q), .mask(mask_q),
    .target(addr_q), .data(data_q), .addr(rom_addr), .dq(rom_dq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= '0;
      step_q  <= '0;
      addr_q  <= '0;
      mask_q  <= '0;
      data_q  <= '0;
      shift_q <= 1'b0;
      slow_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept_ok) begin
            state   <= ST_RUN;
            op_q    <= req_op;
            step_q  <= '0;
            addr_q  <= req_addr;
            mask_q  <= cfg_addr_mask;
            data_q  <= req_data;
            shift_q <= cfg_shift;
            slow_q  <= cfg_slow;
          end else if (accept_bad) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end
        end
        ST_RUN: begin
          if (wr_last) begin
            if (last_step) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              step_q <= step_q + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ce_active  = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign flash_ce_n = !ce_active;
  assign flash_we_n = (phase != PH_STROBE);
  assign flash_addr = ce_active ? rom_addr : '0;
  assign flash_dq   = ce_active ? rom_dq   : '0;
  assign busy       = (state == ST_RUN);
  assign done       = done_q;
  assign err        = err_q;

endmodule

// File: rtl/pflash_cmd_seq_chk.sv
module pflash_cmd_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [ADDR_W-1:0] flash_addr,
  input logic              flash_we_n,
  input logic              flash_ce_n,
  input logic              accept_bad,
  input logic              wr_last
);

  // R7
  we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_we_n |-> !flash_ce_n);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_we_n |=> $stable(flash_addr));

  // R7
  hold_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_we_n) |-> !flash_ce_n);

  // R9
  bad_op_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_bad |=> (done && err && flash_ce_n && flash_we_n));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R8
  write_end_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |-> flash_we_n);

endmodule

bind pflash_cmd_seq pflash_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .flash_addr(flash_addr), .flash_we_n(flash_we_n), .flash_ce_n(flash_ce_n),
  .accept_bad(accept_bad), .wr_last(wr_last)
);

// File: tb/pflash_cmd_seq_tb.sv
`timescale 1ns/1ps
module pflash_cmd_seq_tb;

  localparam int AW  = 20;
  localparam int WEC = 3;
  localparam int GPC = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          cfg_shift = 1'b0;
  logic [AW-1:0] cfg_addr_mask = '1;
  logic          cfg_slow = 1'b0;
  logic          busy, done, err, flash_we_n, flash_ce_n;
  logic [AW-1:0] flash_addr;
  logic [7:0]    flash_dq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [AW-1:0] exp_addr_q[$];
  logic [7:0]    exp_dq_q[$];
  string         exp_tag_q[$];

  always #2 clk = ~clk;

  pflash_cmd_seq #(.ADDR_W(AW), .WE_CYCLES(WEC), .GAP_CYCLES(GPC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .cfg_shift(cfg_shift),
    .cfg_addr_mask(cfg_addr_mask), .cfg_slow(cfg_slow), .busy(busy),
    .done(done), .err(err), .flash_addr(flash_addr), .flash_dq(flash_dq),
    .flash_we_n(flash_we_n), .flash_ce_n(flash_ce_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // unlock address as the requirements state it
  function automatic logic [AW-1:0] unlock(input bit first, input bit sh, input logic [AW-1:0] m);
    logic [AW-1:0] v;
    if (first ^ sh) v = AW'(20'h05555);
    else            v = AW'(20'h02AAA);
    return v & m;
  endfunction

  task automatic push(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
    exp_addr_q.push_back(a);
    exp_dq_q.push_back(d);
    exp_tag_q.push_back(tag);
  endtask

  // monitor: compares each write-enable strobe with the scoreboard
  logic prev_we = 1'b1;
  int   low_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!flash_we_n && prev_we) begin
        if (exp_addr_q.size() == 0) begin
          check(0, "R10 unexpected write", int'(flash_addr), 0);
        end else begin
          logic [AW-1:0] ea;
          logic [7:0]    ed;
          string         tg;
          ea = exp_addr_q.pop_front();
          ed = exp_dq_q.pop_front();
          tg = exp_tag_q.pop_front();
          check(flash_addr == ea, {tg, " addr"}, int'(flash_addr), int'(ea));
          check(flash_dq == ed, {tg, " data"}, int'(flash_dq), int'(ed));
        end
      end
      if (!flash_we_n) low_cnt++;
      else if (!prev_we) begin
        check(low_cnt == WEC, "R7 strobe width", low_cnt, WEC);
        check(!flash_ce_n, "R7 hold cycle ce", int'(flash_ce_n), 0);
        low_cnt = 0;
      end
      prev_we = flash_we_n;
    end
  end

  // driver: called at a negedge, returns at the negedge where done is seen
  task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                        input bit sh, input logic [AW-1:0] m, input bit slow, input string tag);
    int n, nw, expc;
    bit good;
    good = (op <= 3'd3);
    if (good) begin
      push(unlock(1, sh, m), 8'hAA, {tag, " R2 first unlock"});
      push(unlock(0, sh, m), 8'h55, {tag, " R2 second unlock"});
      if (op == 3'd0) begin
        push(unlock(1, sh, m), 8'hA0, {tag, " R5 program cmd"});
        push(a, d, {tag, " R5 program data"});
        nw = 4;
      end else begin
        push(unlock(1, sh, m), 8'h80, {tag, " R6 erase setup"});
        push(unlock(1, sh, m), 8'hAA, {tag, " R6 second prefix"});
        push(unlock(0, sh, m), 8'h55, {tag, " R6 second prefix"});
        case (op)
          3'd1:    push(a, 8'h30, {tag, " R6 sector final"});
          3'd2:    push(a, 8'h50, {tag, " R6 block final"});
          default: push(unlock(1, sh, m), 8'h10, {tag, " R6 chip final"});
        endcase
        nw = 6;
      end
      expc = nw * (2 + WEC + (slow ? GPC : 0));
    end else begin
      expc = 0;
    end
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    cfg_shift = sh; cfg_addr_mask = m; cfg_slow = slow;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_shift = ~sh; cfg_addr_mask = '0; cfg_slow = ~slow; req_data = ~d;
    if (good) check(busy == 1'b1, {tag, " R11 busy after accept"}, int'(busy), 1);
    n = 0;
    while (!done && n < 2000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    check(n == expc, {tag, " R8 done timing"}, n, expc);
    check(err == !good, {tag, " R9 err flag"}, int'(err), int'(!good));
    check(exp_addr_q.size() == 0, {tag, " R2 all writes seen"}, exp_addr_q.size(), 0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(flash_we_n && flash_ce_n, "R1 strobes idle", {flash_we_n, flash_ce_n}, 3);
    check(flash_addr == '0, "R1 addr zero", int'(flash_addr), 0);
    check(!busy && !done && !err, "R1 status low", {busy, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(3'd0, 20'hABCDE, 8'h3C, 0, '1, 0, "prog normal R2");
    run_op(3'd0, 20'h01234, 8'hC5, 1, '1, 0, "prog shifted R3");
    run_op(3'd1, 20'hF7000, 8'h00, 0, 20'h03FFF, 1, "sector masked R4");
    run_op(3'd2, 20'hFFFFF, 8'h00, 1, 20'h07FFF, 0, "block shifted R6");
    run_op(3'd3, 20'h12345, 8'h00, 0, '1, 1, "chip normal R6");
    run_op(3'd3, 20'h00000, 8'h00, 1, 20'h00FFF, 0, "chip masked R4");
    run_op(3'd5, 20'h00010, 8'h11, 0, '1, 0, "bad op5 R9");
    run_op(3'd7, 20'h00020, 8'h22, 1, '1, 1, "bad op7 R9");
    run_op(3'd0, 20'h00055, 8'h99, 0, '1, 1, "prog after error R11");

    // R10: a request raised mid-sequence must be ignored
    fork
      run_op(3'd0, 20'h4AAAA, 8'h5A, 0, '1, 1, "prog with poke R10");
      begin
        repeat (6) @(negedge clk);
        req_valid = 1'b1; req_op = 3'd3;
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    repeat (40) begin
      @(negedge clk);
      if (done || busy || !flash_ce_n) begin
        check(0, "R10 activity after ignored request", {done, busy, flash_ce_n}, 1);
      end
    end
    check(!busy, "R10 idle after ignored request", int'(busy), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule